// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block sits between a 16-bit register port and a NAND flash bus. Software loads a command byte, an address byte and a few configuration fields, then writes a single one-hot trigger bit. The block runs exactly one bus phase in response: a command latch cycle, an address latch cycle, a page program from the local byte buffer, a page read into that buffer, an identifier read or a status read. A full page operation is built by software from a chain of such triggers.

When the phase ends, a sticky completion flag in the trigger register goes to 1 and stays there until software writes a 0 into it. An interrupt output follows that flag unless a mask bit is set. The block follows the device ready/busy line itself: reads start only once the device is ready, and a program does not complete until the device is ready again. Chip-enable gating, selection of one of four chip selects, a pages-per-erase-block field and a self-clearing soft reset complete the block. The byte buffer itself lives outside; the block only addresses it.

Top module: `nand_op_sequencer`

Register map (3-bit `reg_addr`): 0 = configuration, 1 = buffer/chip select, 2 = flash command, 3 = flash address, 4 = operation trigger. Reads are combinational.

## Requirements
- R1: After `rst_n` is released the trigger register reads 0x0000, configuration reads 0x0002, buffer/chip select reads 0x0000, all four `nf_ce_n` are 1, `nf_we_n` and `nf_re_n` are 1, `nf_cle`, `nf_ale` and `irq` are 0, and `pages_per_block` is 32.
- R2: Writing trigger bit 0 runs a command cycle: `nf_cle`=1 and `nf_dq_o` carries bits 7:0 of the command register for one setup clock, then `nf_we_n` is 0 for the strobe width, then one hold clock with `nf_we_n`=1 and `nf_cle` still 1; with the default width 2, the completion flag (trigger bit 15) reads 1 four clocks after the triggering write edge. `nf_cle` and `nf_ale` are never 1 together.
- R3: Writing trigger bit 1 runs the same cycle with `nf_ale`=1 and bits 7:0 of the address register on the bus.
- R4: Configuration bits 2:0 set the number of clocks `nf_we_n` and `nf_re_n` stay low per byte; the value 0 behaves as 1.
- R5: Trigger bit 15 is set when an operation completes and is cleared only by a trigger write with bit 15 at 0; writing 1 there leaves it. While an operation runs, trigger bit 14 reads 1 and bits 5:0 show the running operation.
- R6: `irq` is 1 while the completion flag is 1 and configuration bit 4 (mask) is 0; with the mask at 1, `irq` stays 0 and the flag still sets.
- R7: A trigger write while an operation runs, or one whose bits 5:0 do not hold exactly one 1, starts nothing.
- R8: Trigger bit 2 (program) drives PAGE_BYTES bytes read from buffer address {buffer select, byte index} with one write strobe each and `nf_dq_oe`=1, then waits for `nf_rb_n`=1 before completing.
- R9: Trigger bits 3 (page read), 4 (ID read, ID_BYTES bytes) and 5 (status read, one byte) wait for `nf_rb_n`=1, then read bytes with `nf_re_n` strobes, writing each byte into buffer address {buffer select, byte index} on the last low clock of its strobe; buffer bytes beyond the count are left alone. `nf_we_n` and `nf_re_n` are never 0 together.
- R10: With configuration bit 7 at 1, `nf_ce_n` is 0 only at the index held in buffer/chip-select bits 6:5; with bit 7 at 0, all four are 1. Bits 2:0 of that register select the buffer.
- R11: `pages_per_block` is 32, 64, 128 or 256 for configuration bits 10:9 equal to 0, 1, 2 or 3.
- R12: Writing configuration with bit 6 at 1 aborts any operation, returns all registers to their reset values, reads bit 6 as 1 for RST_CYCLES clocks and ignores register writes in that time, then clears bit 6 by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 3 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| nf_ce_n | output | 4 | Chip enables, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Bus data out |
| nf_dq_oe | output | 1 | Bus output enable |
| nf_dq_i | input | 8 | Bus data in |
| nf_rb_n | input | 1 | Device ready (1) / busy (0) |
| buf_addr | output | 3+log2(PAGE_BYTES) | Buffer byte address |
| buf_rdata | input | 8 | Buffer read data |
| buf_wdata | output | 8 | Buffer write data |
| buf_we | output | 1 | Buffer write enable |
| pages_per_block | output | 9 | Decoded pages per erase block |

## Verification
A corrupted phase state shows at once on the latch enables and strobes: a phase stuck in setup or hold leaves `nf_cle` or `nf_ale` high past the fourth clock, and a skipped ready wait shows as `nf_re_n` pulses while `nf_rb_n` is low. A wrong byte index shows as the wrong count of strobes or as buffer bytes written past the ID or status length, visible once the operation's flag sets. A lost or doubled flag update is seen on the next read of the trigger register and on `irq` in the same clock.

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer #(
  parameter int PAGE_BYTES = 8,
  parameter int ID_BYTES   = 4,
  parameter int RST_CYCLES = 4,
  parameter int WE_DEFAULT = 2,
  localparam int IDX_W  = $clog2(PAGE_BYTES),
  localparam int BUF_AW = 3 + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              irq,
  output logic [3:0]        nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [7:0]        nf_dq_o,
  output logic              nf_dq_oe,
  input  logic [7:0]        nf_dq_i,
  input  logic              nf_rb_n,
  output logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_rdata,
  output logic [7:0]        buf_wdata,
  output logic              buf_we,
  output logic [8:0]        pages_per_block
);

  localparam int NW   = IDX_W + 1;
  localparam int RC_W = $clog2(RST_CYCLES + 1);
  localparam logic [2:0] A_CFG = 3'd0, A_SEL = 3'd1, A_CMD = 3'd2, A_ADR = 3'd3, A_TRG = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SETUP, S_STROBE, S_HOLD, S_POST} st_t;

  st_t              st;
  logic [2:0]       cfg_w;
  logic             cfg_mask, cfg_ce;
  logic [1:0]       cfg_ppb;
  logic [2:0]       buf_sel;
  logic [1:0]       cs_sel;
  logic [15:0]      cmd_q, addr_q;
  logic [5:0]       op_q;
  logic             done_q;
  logic [2:0]       cnt;
  logic [IDX_W-1:0] idx;
  logic [RC_W-1:0]  rst_cnt;

  logic busy, rst_act, is_out, is_in, in_phase, last_byte, strobe_end;
  logic wr_cfg, wr_sel, wr_cmd, wr_adr, wr_trg, srst, trig_ok;
  logic [2:0]  w_eff;
  logic [NW-1:0] nbytes;

  assign busy     = (st != S_IDLE);
  assign rst_act  = (rst_cnt != '0);
  assign is_out   = op_q[0] | op_q[1] | op_q[2];
  assign is_in    = op_q[3] | op_q[4] | op_q[5];
  assign in_phase = (st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD);
  assign w_eff    = (cfg_w == 3'd0) ? 3'd1 : cfg_w;
  assign strobe_end = (cnt == w_eff - 3'd1);

  always_comb begin
    if (op_q[2] | op_q[3])  nbytes = NW'(PAGE_BYTES);
    else if (op_q[4])       nbytes = NW'(ID_BYTES);
    else                    nbytes = NW'(1);
  end
  assign last_byte = ({1'b0, idx} == nbytes - NW'(1));

  assign wr_cfg  = reg_we && !rst_act && (reg_addr == A_CFG);
  assign wr_sel  = reg_we && !rst_act && (reg_addr == A_SEL);
  assign wr_cmd  = reg_we && !rst_act && (reg_addr == A_CMD);
  assign wr_adr  = reg_we && !rst_act && (reg_addr == A_ADR);
  assign wr_trg  = reg_we && !rst_act && (reg_addr == A_TRG);
  assign srst    = wr_cfg && reg_wdata[6];
  assign trig_ok = wr_trg && !busy && $onehot(reg_wdata[5:0]);

  assign nf_cle   = in_phase && op_q[0];
  assign nf_ale   = in_phase && op_q[1];
  assign nf_dq_oe = in_phase && is_out;
  assign nf_we_n  = !((st == S_STROBE) && is_out);
  assign nf_re_n  = !((st == S_STROBE) && is_in);
  assign nf_dq_o  = op_q[0] ? cmd_q[7:0] : op_q[1] ? addr_q[7:0] : op_q[2] ? buf_rdata : 8'h00;
  assign nf_ce_n  = cfg_ce ? ~(4'b0001 << cs_sel) : 4'hF;

  assign buf_addr  = {buf_sel, idx};
  assign buf_wdata = nf_dq_i;
  assign buf_we    = (st == S_STROBE) && is_in && strobe_end;

  assign irq             = done_q && !cfg_mask;
  assign pages_per_block = 9'd32 << cfg_ppb;

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {5'b0, cfg_ppb, 1'b0, cfg_ce, rst_act, 1'b0, cfg_mask, 1'b0, cfg_w};
      A_SEL:   reg_rdata = {9'b0, cs_sel, 2'b0, buf_sel};
      A_CMD:   reg_rdata = cmd_q;
      A_ADR:   reg_rdata = addr_q;
      A_TRG:   reg_rdata = {done_q, busy, 8'b0, op_q};
      default: reg_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      st       <= S_IDLE;
      cfg_w    <= 3'(WE_DEFAULT);
      cfg_mask <= 1'b0;
      cfg_ce   <= 1'b0;
      cfg_ppb  <= 2'd0;
      buf_sel  <= 3'd0;
      cs_sel   <= 2'd0;
      cmd_q    <= 16'h0000;
      addr_q   <= 16'h0000;
      op_q     <= 6'd0;
      done_q   <= 1'b0;
      cnt      <= 3'd0;
      idx      <= '0;
      rst_cnt  <= (rst_n && srst) ? RC_W'(RST_CYCLES) : '0;
    end else if (rst_act) begin
      rst_cnt <= rst_cnt - RC_W'(1);
    end else begin
      if (wr_cfg) begin
        cfg_w    <= reg_wdata[2:0];
        cfg_mask <= reg_wdata[4];
        cfg_ce   <= reg_wdata[7];
        cfg_ppb  <= reg_wdata[10:9];
      end
      if (wr_sel) begin
        buf_sel <= reg_wdata[2:0];
        cs_sel  <= reg_wdata[6:5];
      end
      if (wr_cmd) cmd_q  <= reg_wdata;
      if (wr_adr) addr_q <= reg_wdata;
      if (wr_trg && !reg_wdata[15]) done_q <= 1'b0;

      case (st)
        S_IDLE: if (trig_ok) begin
          op_q <= reg_wdata[5:0];
          idx  <= '0;
          cnt  <= 3'd0;
          st   <= (reg_wdata[3] | reg_wdata[4] | reg_wdata[5]) ? S_PRE : S_SETUP;
        end
        S_PRE: if (nf_rb_n) st <= S_SETUP;
        S_SETUP: begin
          cnt <= 3'd0;
          st  <= S_STROBE;
        end
        S_STROBE: if (strobe_end) st <= S_HOLD;
                  else cnt <= cnt + 3'd1;
        S_HOLD: if (!last_byte) begin
          idx <= idx + IDX_W'(1);
          st  <= S_SETUP;
        end else if (op_q[2]) begin
          st <= S_POST;
        end else begin
          st     <= S_IDLE;
          op_q   <= 6'd0;
          done_q <= 1'b1;
        end
        S_POST: if (nf_rb_n) begin
          st     <= S_IDLE;
          op_q   <= 6'd0;
          done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(nf_cle && nf_ale));
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!nf_we_n && !nf_re_n));
  // R8
  we_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) !nf_we_n |-> nf_dq_oe);
  // R5
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_q) |-> $past(busy));
  // R7
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(op_q));
  // R12
  srst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_act |-> (!busy && !done_q));
  // R9
  rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n) ($past(st == S_PRE) && !$past(nf_rb_n) && !$past(rst_act) && !$past(srst)) |-> (st == S_PRE));

endmodule

// File: tb/test_nand_op_sequencer.sv
module test_nand_op_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CFG = 3'd0, A_SEL = 3'd1, A_CMD = 3'd2, A_ADR = 3'd3, A_TRG = 3'd4;

  localparam logic [15:0] CFG_V [8] = '{16'h0082, 16'h0282, 16'h0482, 16'h0682,
                                        16'h0002, 16'h0602, 16'h0082, 16'h0482};
  localparam logic [15:0] SEL_V [8] = '{16'h0000, 16'h0020, 16'h0040, 16'h0060,
                                        16'h0060, 16'h0020, 16'h0065, 16'h0007};
  localparam logic [3:0]  CE_V  [8] = '{4'b1110, 4'b1101, 4'b1011, 4'b0111,
                                        4'b1111, 4'b1111, 4'b0111, 4'b1110};
  localparam logic [8:0]  PPB_V [8] = '{9'd32, 9'd64, 9'd128, 9'd256,
                                        9'd32, 9'd256, 9'd32, 9'd128};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic reg_we = 1'b0;
  logic [15:0] reg_wdata = 16'h0, reg_rdata;
  logic irq, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, buf_we;
  logic nf_rb_n = 1'b1;
  logic [3:0] nf_ce_n;
  logic [7:0] nf_dq_o, nf_dq_i, buf_rdata, buf_wdata;
  logic [5:0] buf_addr;
  logic [8:0] pages_per_block;

  int checks = 0, fails = 0;
  int rd_cnt = 0, log_n = 0, we_low = 0, re_low = 0, ale_seen = 0;
  logic [7:0] mem [64];
  logic [7:0] log_d [16];
  logic [1:0] log_c [16];
  logic [15:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_op_sequencer i_nand_op_sequencer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe),
    .nf_dq_i(nf_dq_i), .nf_rb_n(nf_rb_n), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .buf_wdata(buf_wdata), .buf_we(buf_we), .pages_per_block(pages_per_block));

  assign buf_rdata = mem[buf_addr];
  assign nf_dq_i   = 8'hA0 + rd_cnt[7:0];
  always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;
  always @(posedge nf_re_n) if (rst_n) rd_cnt = rd_cnt + 1;
  always @(posedge nf_we_n) if (rst_n && nf_dq_oe === 1'b1 && log_n < 16) begin
    log_d[log_n] = nf_dq_o;
    log_c[log_n] = {nf_cle, nf_ale};
    log_n = log_n + 1;
  end
  always @(negedge clk) begin
    if (nf_we_n === 1'b0) we_low = we_low + 1;
    if (nf_re_n === 1'b0) re_low = re_low + 1;
    if (nf_ale === 1'b1) ale_seen = ale_seen + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    logic [15:0] t;
    t = 16'h0;
    for (int k = 0; k < 400; k++) begin
      rd(A_TRG, t);
      if (t[15]) break;
      @(negedge clk);
    end
    check(req, {31'b0, t[15]}, 32'd1);
  endtask

  task automatic clear_counts();
    log_n = 0; we_low = 0; re_low = 0; ale_seen = 0; rd_cnt = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(A_TRG, v); check("R1 trig", v, 16'h0000);
    rd(A_CFG, v); check("R1 cfg", v, 16'h0002);
    rd(A_SEL, v); check("R1 sel", v, 16'h0000);
    check("R1 pins", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, irq}, {4'hF, 1'b1, 1'b1, 3'b000});
    check("R1 ppb", pages_per_block, 9'd32);

    // R10 R11 vector table
    for (int i = 0; i < 8; i++) begin
      wr(A_CFG, CFG_V[i]);
      wr(A_SEL, SEL_V[i]);
      check("R10 ce_n", nf_ce_n, CE_V[i]);
      check("R11 ppb", pages_per_block, PPB_V[i]);
      rd(A_CFG, v); check("R10 cfg readback", v, CFG_V[i]);
      rd(A_SEL, v); check("R10 sel readback", v, SEL_V[i]);
    end
    wr(A_CFG, 16'h0002);
    wr(A_SEL, 16'h0000);

    // R2 command cycle, exact timing
    wr(A_CMD, 16'h1270);
    clear_counts();
    wr(A_TRG, 16'h0001);
    check("R2 setup", {nf_cle, nf_we_n, nf_dq_oe, nf_dq_o}, {3'b111, 8'h70});
    step(1); check("R2 strobe1", {nf_cle, nf_we_n}, 2'b10);
    step(1); check("R2 strobe2", {nf_cle, nf_we_n}, 2'b10);
    step(1); check("R2 hold", {nf_cle, nf_we_n}, 2'b11);
    rd(A_TRG, v); check("R5 busy and op", v, 16'h4001);
    step(1); check("R2 cle off", nf_cle, 1'b0);
    rd(A_TRG, v); check("R2 done at 4", v, 16'h8000);
    check("R6 irq unmasked", irq, 1'b1);

    // R5 sticky flag
    wr(A_TRG, 16'h8000);
    rd(A_TRG, v); check("R5 write 1 keeps", v, 16'h8000);
    // R6 mask
    wr(A_CFG, 16'h0012);
    check("R6 irq masked", irq, 1'b0);
    rd(A_TRG, v); check("R6 flag with mask", v, 16'h8000);
    wr(A_CFG, 16'h0002);
    check("R6 irq unmask", irq, 1'b1);
    wr(A_TRG, 16'h0000);
    rd(A_TRG, v); check("R5 write 0 clears", v, 16'h0000);
    check("R6 irq cleared", irq, 1'b0);

    // R3 address cycle
    wr(A_ADR, 16'hAB5C);
    clear_counts();
    wr(A_TRG, 16'h0002);
    wait_done("R3 done");
    check("R3 byte", {log_n, log_d[0], log_c[0]}, {32'd1, 8'h5C, 2'b01});
    check("R3 width", we_low, 2);
    wr(A_TRG, 16'h0000);

    // R4 strobe width
    wr(A_CFG, 16'h0000);
    clear_counts();
    wr(A_TRG, 16'h0001);
    wait_done("R4 done w0");
    check("R4 width 0 acts as 1", we_low, 1);
    wr(A_CFG, 16'h0005);
    clear_counts();
    wr(A_TRG, 16'h0000);
    wr(A_TRG, 16'h0001);
    wait_done("R4 done w5");
    check("R4 width 5", we_low, 5);
    wr(A_TRG, 16'h0000);

    // R7 trigger while busy, and non one-hot trigger
    wr(A_CFG, 16'h0007);
    wr(A_CMD, 16'h0090);
    clear_counts();
    wr(A_TRG, 16'h0001);
    wr(A_TRG, 16'h0002);
    wait_done("R7 done");
    check("R7 no address cycle", ale_seen, 0);
    check("R7 one byte", {log_n, log_d[0], log_c[0]}, {32'd1, 8'h90, 2'b10});
    wr(A_TRG, 16'h0000);
    wr(A_CFG, 16'h0002);
    clear_counts();
    wr(A_TRG, 16'h0003);
    step(4);
    rd(A_TRG, v); check("R7 multi-bit ignored", v, 16'h0000);
    check("R7 no strobe", we_low + re_low, 0);

    // R9 page read waits for ready
    nf_rb_n = 1'b0;
    clear_counts();
    wr(A_TRG, 16'h0008);
    step(6);
    check("R9 no read while busy", re_low, 0);
    rd(A_TRG, v); check("R9 busy while waiting", v, 16'h4008);
    nf_rb_n = 1'b1;
    wait_done("R9 page done");
    for (int i = 0; i < 8; i++) check("R9 page byte", mem[i], 8'hA0 + 8'(i));
    check("R9 re strobes", re_low, 16);
    wr(A_TRG, 16'h0000);

    // R9 ID read length
    mem[4] = 8'hEE;
    clear_counts();
    wr(A_TRG, 16'h0010);
    wait_done("R9 id done");
    for (int i = 0; i < 4; i++) check("R9 id byte", mem[i], 8'hA0 + 8'(i));
    check("R9 id length", mem[4], 8'hEE);
    wr(A_TRG, 16'h0000);

    // R9 status read length
    mem[0] = 8'h00; mem[1] = 8'hEE;
    clear_counts();
    wr(A_TRG, 16'h0020);
    wait_done("R9 status done");
    check("R9 status byte", {mem[0], mem[1]}, {8'hA0, 8'hEE});
    wr(A_TRG, 16'h0000);

    // R8 program from buffer 1, completion waits for ready
    for (int i = 0; i < 8; i++) mem[8 + i] = 8'h30 + 8'(i);
    wr(A_SEL, 16'h0001);
    nf_rb_n = 1'b0;
    clear_counts();
    wr(A_TRG, 16'h0004);
    for (int k = 0; k < 300; k++) begin
      if (log_n >= 8) break;
      @(negedge clk);
    end
    step(3);
    rd(A_TRG, v); check("R8 waits for ready", v[15:14], 2'b01);
    nf_rb_n = 1'b1;
    wait_done("R8 done");
    check("R8 byte count", log_n, 8);
    for (int i = 0; i < 8; i++) check("R8 program byte", {log_d[i], log_c[i]}, {8'h30 + 8'(i), 2'b00});
    wr(A_TRG, 16'h0000);

    // R12 soft reset aborts and self-clears
    wr(A_CFG, 16'h0493);
    wr(A_SEL, 16'h0060);
    nf_rb_n = 1'b0;
    clear_counts();
    wr(A_TRG, 16'h0008);
    step(2);
    wr(A_CFG, 16'h0040);
    rd(A_CFG, v); check("R12 bit reads 1", v, 16'h0042);
    rd(A_TRG, v); check("R12 op aborted", v, 16'h0000);
    check("R12 ce released", nf_ce_n, 4'hF);
    wr(A_SEL, 16'h0060);
    step(5);
    rd(A_CFG, v); check("R12 bit self-clears", v, 16'h0002);
    rd(A_SEL, v); check("R12 write ignored", v, 16'h0000);
    nf_rb_n = 1'b1;
    step(4);
    check("R12 no read after abort", re_low, 0);
    rd(A_TRG, v); check("R12 no completion", v, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule